// File: doc/BRIEF.md
# Dual-Mode Pixel Group Hit Counter

This block holds the digital counting logic for a 2x2 group of pixels in a photon counting detector. Each pixel has a fixed number of comparators, and each comparator gives single-cycle hit pulses at its own energy threshold. Every comparator has its own counting channel. In the narrow mode, a channel has two counters of `CW` bits that alternate. One counts while the other holds the previous frame for readout, so a frame change loses no hits. In the wide mode, the two halves of a channel chain into one counter of `2*CW` bits. This counter freezes at the frame strobe and stays frozen while it is read out. Every counter saturates at all-ones and raises an overflow flag instead of wrapping.

A merged mode treats the four pixels as one larger pixel. The comparators pair up across pixels, and the group then offers four merged thresholds. Each merged threshold is counted in one of the lower channels. The mode inputs take effect only at an accepted frame strobe. When the mode changes, every counter is cleared. After an accepted strobe with an unchanged mode, the frozen words are shifted out on a serial line, one channel after another.

Top module: `pxc_group_top`

## Requirements
- R1: Channel c is `pixel*NCMP + comparator` and is driven by `hit_i[c]`. A channel adds at most one count per clock cycle, however long its hit input stays high.
- R2: In the narrow mode (`wide_i`=0), an accepted strobe swaps the counting and held halves of every channel. The newly counting half restarts at 1 if the channel has a hit in the strobe cycle, and at 0 otherwise. No hit is lost across the swap.
- R3: In the narrow mode, a counting half that has reached 2^CW-1 stays there on further hits and sets that half's overflow flag. The flag is cleared when the half restarts at a swap.
- R4: In the wide mode (`wide_i`=1), a channel is one 2*CW-bit counter whose low half carries into the high half. It saturates at all-ones and sets an overflow flag.
- R5: In the wide mode, hits are discarded from the accepted strobe cycle until the last readout bit. At the edge that ends the readout, every counter and flag is cleared, and counting resumes in the next cycle.
- R6: An accepted strobe with an unchanged mode makes `valid_o` high from the next cycle for exactly Nact*W consecutive cycles. W is CW in the narrow mode and 2*CW in the wide mode. The words come out in ascending channel order, most significant bit first. `sout_o` and `ovf_o` are 0 while `valid_o` is low.
- R7: While the bits of a word are on `sout_o`, `ovf_o` shows that word's overflow flag.
- R8: In the merged mode (`merge_i`=1), merged threshold m (m < NCH/2) is counted in channel m. Channel m takes the OR of comparator m%NCMP of pixel 2*(m/NCMP) and of pixel 2*(m/NCMP)+1. Coincident hits count once. The upper channels count nothing, and Nact is NCH/2 instead of NCH.
- R9: `wide_i` and `merge_i` are sampled only at an accepted strobe. If they differ from the current mode, every counter and flag is cleared, no readout starts, and the hits of that cycle are dropped.
- R10: A strobe that arrives while `valid_o` is high is ignored. No swap happens, the readout does not restart, and counting continues in the same half.
- R11: After reset, the mode is narrow and unmerged, `valid_o` is low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | NPIX*NCMP | Comparator hit pulses, bit pixel*NCMP+comparator |
| frame_i | input | 1 | Frame boundary strobe |
| wide_i | input | 1 | Requested mode: 1 = chained wide counters |
| merge_i | input | 1 | Requested mode: 1 = 2x2 merged thresholds |
| sout_o | output | 1 | Serial readout data, MSB first |
| valid_o | output | 1 | Readout bit valid |
| ovf_o | output | 1 | Overflow flag of the word being shifted |

## Verification
The counting paths are tried in several ways. Isolated pulses on single channels check exact counts. All hit inputs are then held high, which tells counting per cycle apart from counting per pulse, and held long enough to reach saturation in both widths. Coincident pulses on paired comparators in the merged mode separate an OR of the pair from a sum. Hits in the strobe cycle and strobes during readout land on the swap and frozen windows, which shows whether a hit is lost, counted twice or counted in the wrong frame. Random sparse traffic with random strobes in each mode is compared cycle by cycle with a behavioural model of the serial output.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    // Operating mode of the pixel group, changed only at a frame boundary.
    typedef struct packed {
        logic wide;   // 1: chained counters of double width
        logic merge;  // 1: 2x2 group acts as one pixel
    } pxc_cfg_t;

endpackage

// File: rtl/pxc_hit_route.sv
module pxc_hit_route #(
    parameter int NPIX = 4,
    parameter int NCMP = 2
) (
    input  logic                   merge_i,
    input  logic [NPIX*NCMP-1:0]   hit_i,
    output logic [NPIX*NCMP-1:0]   hit_o
);
    localparam int NCH = NPIX * NCMP;

    for (genvar m = 0; m < NCH; m++) begin : g_ch
        if (m < NCH / 2) begin : g_low
            // merged threshold m pairs the same comparator of two pixels
            localparam int GRP = m / NCMP;
            localparam int CMP = m % NCMP;
            localparam int SRC_A = (2 * GRP) * NCMP + CMP;
            localparam int SRC_B = (2 * GRP + 1) * NCMP + CMP;
            assign hit_o[m] = merge_i ? (hit_i[SRC_A] | hit_i[SRC_B]) : hit_i[m];
        end else begin : g_high
            assign hit_o[m] = merge_i ? 1'b0 : hit_i[m];
        end
    end

endmodule

// File: rtl/pxc_chan.sv
module pxc_chan #(
    parameter int CW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hit_i,
    input  logic            wide_i,
    input  logic            cnt_en_i,
    input  logic            swap_i,
    input  logic            clr_i,
    output logic [2*CW-1:0] rd_word_o,
    output logic            rd_ovf_o
);
    localparam int WW = 2 * CW;

    typedef struct packed {
        logic [1:0][CW-1:0] half;
        logic [1:0]         ovf;
        logic               bank;   // index of the counting half
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [WW-1:0] wide_cnt;
    logic [CW-1:0] act_q, held_q;
    logic          act_ovf_q;

    assign wide_cnt  = {st_q.half[1], st_q.half[0]};
    assign act_q     = st_q.half[st_q.bank];
    assign held_q    = st_q.half[~st_q.bank];
    assign act_ovf_q = st_q.ovf[st_q.bank];

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (wide_i) begin
            if (hit_i && cnt_en_i) begin
                if (&wide_cnt) begin
                    st_d.ovf[0] = 1'b1;
                end else begin
                    {st_d.half[1], st_d.half[0]} = wide_cnt + WW'(1);
                end
            end
        end else if (swap_i) begin
            st_d.bank              = ~st_q.bank;
            st_d.half[~st_q.bank]  = hit_i ? CW'(1) : '0;
            st_d.ovf[~st_q.bank]   = 1'b0;
        end else if (hit_i) begin
            if (&act_q) begin
                st_d.ovf[st_q.bank] = 1'b1;
            end else begin
                st_d.half[st_q.bank] = act_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_word_o = wide_i ? wide_cnt : WW'(held_q);
    assign rd_ovf_o  = wide_i ? st_q.ovf[0] : st_q.ovf[~st_q.bank];

    // R1: the counting half never advances by more than one per cycle
    p_one_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !wide_i && !swap_i)
        |=> (act_q == $past(act_q) || act_q == CW'($past(act_q) + CW'(1))));

    // R2: the held half is untouched between swaps
    p_held_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !wide_i && !swap_i) |=> $stable(held_q));

    // R3: a full narrow half sticks and flags overflow
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !wide_i && !swap_i && hit_i && (&act_q))
        |=> ((&act_q) && act_ovf_q));

    // R4: a full wide counter sticks and flags overflow
    p_wide_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && wide_i && cnt_en_i && hit_i && (&wide_cnt))
        |=> ((&wide_cnt) && st_q.ovf[0]));

    // R5: a frozen wide counter holds its value
    p_wide_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && wide_i && !cnt_en_i) |=> $stable(wide_cnt));

endmodule

// File: rtl/pxc_readout.sv
module pxc_readout #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic                   wide_i,
    input  logic [$clog2(NCH)-1:0] last_ch_i,
    output logic                   busy_o,
    output logic [$clog2(NCH)-1:0] ch_o,
    output logic [$clog2(2*CW)-1:0] bit_o,
    output logic                   done_o
);
    localparam int WW  = 2 * CW;
    localparam int CHW = $clog2(NCH);
    localparam int BW  = $clog2(WW);

    typedef struct packed {
        logic           busy;
        logic [CHW-1:0] ch;
        logic [BW-1:0]  bitc;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [BW-1:0] last_bit;

    assign last_bit = wide_i ? BW'(WW - 1) : BW'(CW - 1);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.bitc == last_bit) begin
                st_d.bitc = '0;
                if (st_q.ch == last_ch_i) st_d.busy = 1'b0;
                else                      st_d.ch   = st_q.ch + CHW'(1);
            end else begin
                st_d.bitc = st_q.bitc + BW'(1);
            end
        end
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.ch   = '0;
            st_d.bitc = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign ch_o   = st_q.ch;
    assign bit_o  = st_q.bitc;
    assign done_o = st_q.busy && (st_q.bitc == last_bit) && (st_q.ch == last_ch_i);

    // R10: a new readout never starts over a running one
    p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !st_q.busy);

    // R6: readout only ends after the last bit of the last word
    p_full_length_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.busy) |-> $past(done_o));

    // R6: bit position stays inside the word
    p_bit_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.bitc <= last_bit));

endmodule

// File: rtl/pxc_group_top.sv
module pxc_group_top
    import pxc_pkg::*;
#(
    parameter int NPIX = 4,
    parameter int NCMP = 2,
    parameter int CW   = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NPIX*NCMP-1:0] hit_i,
    input  logic                 frame_i,
    input  logic                 wide_i,
    input  logic                 merge_i,
    output logic                 sout_o,
    output logic                 valid_o,
    output logic                 ovf_o
);
    localparam int NCH = NPIX * NCMP;
    localparam int WW  = 2 * CW;
    localparam int CHW = $clog2(NCH);
    localparam int BW  = $clog2(WW);

    typedef struct packed {
        pxc_cfg_t cfg;
        logic     frozen;
    } top_st_t;

    top_st_t st_d, st_q;

    logic           busy, done;
    logic [CHW-1:0] rd_ch, last_ch;
    logic [BW-1:0]  rd_bit, bit_idx;
    pxc_cfg_t       req_cfg;
    logic           frame_acc, cfg_chg, start, swap, clr_all, cnt_en;
    logic [NCH-1:0] chan_hit;
    logic [NCH-1:0][WW-1:0] words;
    logic [NCH-1:0] word_ovf;
    logic [WW-1:0]  sel_word;

    assign req_cfg   = '{wide: wide_i, merge: merge_i};
    assign frame_acc = frame_i && !busy;
    assign cfg_chg   = frame_acc && (req_cfg != st_q.cfg);
    assign start     = frame_acc && !cfg_chg;
    assign swap      = start && !st_q.cfg.wide;
    assign clr_all   = cfg_chg || (done && st_q.cfg.wide);
    assign cnt_en    = !st_q.frozen && !start;
    assign last_ch   = st_q.cfg.merge ? CHW'(NCH / 2 - 1) : CHW'(NCH - 1);

    always_comb begin
        st_d = st_q;
        if (cfg_chg) st_d.cfg = req_cfg;
        if (clr_all)                      st_d.frozen = 1'b0;
        else if (start && st_q.cfg.wide)  st_d.frozen = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    pxc_hit_route #(.NPIX(NPIX), .NCMP(NCMP)) route_i (
        .merge_i (st_q.cfg.merge),
        .hit_i   (hit_i),
        .hit_o   (chan_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pxc_chan #(.CW(CW)) chan_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .hit_i     (chan_hit[c]),
            .wide_i    (st_q.cfg.wide),
            .cnt_en_i  (cnt_en),
            .swap_i    (swap),
            .clr_i     (clr_all),
            .rd_word_o (words[c]),
            .rd_ovf_o  (word_ovf[c])
        );
    end

    pxc_readout #(.NCH(NCH), .CW(CW)) rd_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .wide_i    (st_q.cfg.wide),
        .last_ch_i (last_ch),
        .busy_o    (busy),
        .ch_o      (rd_ch),
        .bit_o     (rd_bit),
        .done_o    (done)
    );

    assign sel_word = words[rd_ch];
    assign bit_idx  = (st_q.cfg.wide ? BW'(WW - 1) : BW'(CW - 1)) - rd_bit;
    assign sout_o   = busy & sel_word[bit_idx];
    assign ovf_o    = busy & word_ovf[rd_ch];
    assign valid_o  = busy;

    // R9: mode only moves at an accepted strobe
    p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame_i || valid_o) |=> $stable(st_q.cfg));

    // R6: outputs are quiet outside readout
    p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (!sout_o && !ovf_o));

    // R6: a readout is always launched by a strobe
    p_start_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> $past(frame_i));

    // R5: freezing exists only in the wide mode and only during readout
    p_frozen_wide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.frozen |-> (st_q.cfg.wide && valid_o));

endmodule

// File: tb/pxc_group_top_tb_top.sv
module pxc_group_top_tb_top;
    localparam int NPIX = 4;
    localparam int NCMP = 2;
    localparam int NCH  = NPIX * NCMP;
    localparam int CW   = 6;
    localparam int NMAX = (1 << CW) - 1;
    localparam int WMAX = (1 << (2 * CW)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] hit = '0;
    logic frame = 1'b0, wide = 1'b0, merge = 1'b0;
    logic sout, valid, ovf;

    always #10 clk = ~clk;

    pxc_group_top #(.NPIX(NPIX), .NCMP(NCMP), .CW(CW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .hit_i (hit), .frame_i (frame),
        .wide_i (wide), .merge_i (merge),
        .sout_o (sout), .valid_o (valid), .ovf_o (ovf)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R11";

    // behavioural model
    int  mh [NCH][2];
    bit  mo [NCH][2];
    bit  mb [NCH];
    bit  mwide = 0, mmerge = 0, mbusy = 0, mfrozen = 0;
    int  mch = 0, mbit = 0;

    // captured words
    int  got [NCH];
    bit  gov [NCH];
    int  gk = 0, cap = 0, capn = 0;

    function automatic int wlen();
        return mwide ? 2 * CW : CW;
    endfunction

    function automatic int nact();
        return mmerge ? NCH / 2 : NCH;
    endfunction

    function automatic int mword(int c);
        return mwide ? mh[c][0] : mh[c][!mb[c]];
    endfunction

    function automatic bit movf(int c);
        return mwide ? mo[c][0] : mo[c][!mb[c]];
    endfunction

    function automatic bit routed(logic [NCH-1:0] h, int c);
        if (!mmerge) return h[c];
        if (c >= NCH / 2) return 1'b0;
        return h[(2 * (c / NCMP)) * NCMP + c % NCMP] | h[(2 * (c / NCMP) + 1) * NCMP + c % NCMP];
    endfunction

    task automatic clear_model();
        for (int c = 0; c < NCH; c++) begin
            mh[c][0] = 0; mh[c][1] = 0; mo[c][0] = 0; mo[c][1] = 0; mb[c] = 0;
        end
        mfrozen = 0;
    endtask

    task automatic model_edge(logic [NCH-1:0] h, bit fr, bit wi, bit me);
        if (fr && !mbusy) begin
            if (wi != mwide || me != mmerge) begin
                clear_model();
                mwide = wi; mmerge = me;
            end else begin
                if (!mwide) begin
                    for (int c = 0; c < NCH; c++) begin
                        mb[c] = !mb[c];
                        mh[c][mb[c]] = routed(h, c) ? 1 : 0;
                        mo[c][mb[c]] = 0;
                    end
                end else begin
                    mfrozen = 1;
                end
                mbusy = 1; mch = 0; mbit = 0;
                gk = 0; cap = 0; capn = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (routed(h, c)) begin
                    if (mwide) begin
                        if (!mfrozen) begin
                            if (mh[c][0] == WMAX) mo[c][0] = 1; else mh[c][0]++;
                        end
                    end else begin
                        if (mh[c][mb[c]] == NMAX) mo[c][mb[c]] = 1; else mh[c][mb[c]]++;
                    end
                end
            end
            if (mbusy) begin
                if (mbit == wlen() - 1) begin
                    mbit = 0;
                    if (mch == nact() - 1) begin
                        mbusy = 0;
                        if (mwide) clear_model();
                    end else mch++;
                end else mbit++;
            end
        end
    endtask

    task automatic check_outputs();
        bit ev, es, eo;
        ev = mbusy;
        es = mbusy ? ((mword(mch) >> (wlen() - 1 - mbit)) & 1) : 1'b0;
        eo = mbusy ? movf(mch) : 1'b0;
        n_chk++;
        if (valid !== ev || sout !== es || ovf !== eo) begin
            n_fail++;
            $display("FAIL %s: valid/sout/ovf actual %b%b%b expected %b%b%b",
                     cur_req, valid, sout, ovf, ev, es, eo);
        end
        if (valid === 1'b1) begin
            cap = (cap << 1) | int'(sout);
            capn++;
            if (capn == wlen()) begin
                if (gk < NCH) begin
                    got[gk] = cap; gov[gk] = ovf;
                end
                gk++; cap = 0; capn = 0;
            end
        end
    endtask

    task automatic step(logic [NCH-1:0] h, bit fr, bit wi, bit me);
        @(negedge clk);
        check_outputs();
        hit = h; frame = fr; wide = wi; merge = me;
        model_edge(h, fr, wi, me);
    endtask

    task automatic hits(logic [NCH-1:0] h, int n);
        for (int i = 0; i < n; i++) step(h, 0, mwide, mmerge);
    endtask

    task automatic frame_read(logic [NCH-1:0] h);
        step(h, 1, mwide, mmerge);
        while (mbusy) step('0, 0, mwide, mmerge);
    endtask

    task automatic check_val(string tag, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            logic [NCH-1:0] h;
            h = NCH'($urandom & $urandom);
            step(h, ($urandom % 16) == 0, mwide, mmerge);
        end
        while (mbusy) step('0, 0, mwide, mmerge);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        cur_req = "R11";
        hits('0, 2);
        frame_read('0);
        check_val("R11 word count", gk, NCH);
        for (int c = 0; c < NCH; c++) check_val("R11 zero word", got[c], 0);

        // R2, R6: isolated pulses, strobe-cycle hit goes to new frame
        cur_req = "R6";
        for (int i = 0; i < 5; i++) begin hits(8'h01, 1); hits('0, 1); end
        for (int i = 0; i < 2; i++) begin hits(8'h08, 1); hits('0, 2); end
        frame_read(8'h01);
        check_val("R6 words", gk, NCH);
        check_val("R6 ch0", got[0], 5);
        check_val("R6 ch3", got[3], 2);
        cur_req = "R2";
        frame_read('0);
        check_val("R2 strobe hit kept", got[0], 1);

        // R1: held-high hits count once per cycle
        cur_req = "R1";
        hits('1, 10);
        frame_read('0);
        for (int c = 0; c < NCH; c++) check_val("R1 per-cycle", got[c], 10);

        // R3, R7: saturation and flag
        cur_req = "R3";
        hits('1, 70);
        frame_read('0);
        check_val("R3 saturated", got[5], NMAX);
        check_val("R7 flag set", int'(gov[5]), 1);
        frame_read('0);
        check_val("R7 flag cleared", int'(gov[5]), 0);

        // R10: strobes during readout ignored
        cur_req = "R10";
        step('0, 1, mwide, mmerge);
        for (int i = 0; i < 3; i++) step(8'h01, 1, mwide, mmerge);
        while (mbusy) step('0, 0, mwide, mmerge);
        frame_read('0);
        check_val("R10 hits kept", got[0], 3);

        cur_req = "R2";
        random_run(400);

        // R9, R8: switch to merged mode
        cur_req = "R9";
        step(8'hFF, 1, 0, 1);
        hits('0, 3);
        frame_read('0);
        check_val("R8 merged words", gk, NCH / 2);
        check_val("R9 cleared", got[0], 0);
        cur_req = "R8";
        hits(8'h05, 4); hits(8'h02, 2); hits(8'h40, 3); hits(8'h80, 1);
        frame_read('0);
        check_val("R8 ch0 coincident once", got[0], 4);
        check_val("R8 ch1", got[1], 2);
        check_val("R8 ch2 from pixel3", got[2], 3);
        check_val("R8 ch3", got[3], 1);
        random_run(400);

        // R4: wide mode, carry and saturation
        cur_req = "R4";
        step('1, 1, 1, 0);
        hits('1, 70);
        frame_read('0);
        check_val("R4 carry", got[2], 70);
        hits('1, WMAX + 5);
        frame_read('0);
        check_val("R4 wide saturate", got[7], WMAX);
        check_val("R7 wide flag", int'(gov[7]), 1);

        // R5: hits discarded while frozen, clear after readout
        cur_req = "R5";
        step('1, 1, mwide, mmerge);
        while (mbusy) step('1, 0, mwide, mmerge);
        frame_read('0);
        check_val("R5 frozen hits dropped", got[1], 0);
        hits(8'h02, 3);
        frame_read('0);
        check_val("R5 resumes", got[1], 3);
        random_run(400);

        cur_req = "R11";
        hits('0, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule